// File: doc/BRIEF.md
# Double-Buffered Route Table Swap Controller

This block manages four double-buffered routing tables for a two-channel time-division serial interface. Channel A and channel B each have a receive table and a transmit table. Every table has two halves: the one in use and a spare one that software refills. Software writes a new routing into the spare half and then sets that table's request bit in the command register. At the next frame-sync strobe for that table, the block exchanges the halves by flipping the table's select line. In the same cycle it clears the request bit, which tells software the swap is done.

Each table is governed by a two-state machine. The states are `ST_IDLE` (no swap waiting, spare half free to write) and `ST_PENDING` (spare half valid, swap armed).
- `T_ARM` goes from `ST_IDLE` to `ST_PENDING`. It is taken on a command write with a 1 in that table's bit while the partition mode allows swaps.
- `T_FIRE` goes from `ST_PENDING` back to `ST_IDLE`. It is taken on the table's own frame-sync strobe while the mode allows swaps.
- In every other case the state holds (`T_HOLD`).

Soft reset returns every machine to `ST_IDLE` but leaves the select bits alone. Hard reset clears both.

Top module: `route_swap_ctrl`

## Requirements
- R1: Command and status registers are 8 bits wide. Bit 0 is channel A receive, bit 1 is channel A transmit, bit 2 is channel B receive and bit 3 is channel B transmit. Bits 7:4 always read 0.
- R2: Writing the command register (`reg_addr`=0) with a 1 in bit i sets request bit i on the next clock, but only while `part_mode` is 01 or 11.
- R3: While `part_mode` is 00 or 10, command writes set no request bit and no swap takes place.
- R4: A pending request i is applied on the first clock where `fsync[i]` is high and the mode allows swaps. On that clock, status bit i toggles and request bit i clears together. Strobes of other tables leave table i unchanged.
- R5: Writing 0 to a pending request bit does not cancel it. Writing 1 to an already pending bit changes nothing.
- R6: The status register (`reg_addr`=1) is read-only. Writes to it have no effect.
- R7: `route_sel[i]` always equals status bit i.
- R8: Soft reset clears every request bit and leaves the status bits unchanged.
- R9: Hard reset clears both the request bits and the status bits.
- R10: A request that is pending while the mode leaves the allowed set stays pending. It is applied at the first own strobe after the mode is allowed again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| hard_rst_n | input | 1 | Asynchronous active-low hard reset, clears all state |
| soft_rst_n | input | 1 | Asynchronous active-low soft reset, clears requests only |
| part_mode | input | 2 | Routing memory partition mode; swaps allowed for 01 and 11 |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 selects command register, 1 selects status register |
| reg_wdata | input | 8 | Register write data |
| fsync | input | 4 | Per-table frame-sync strobes, bit order as in R1 |
| cmd_rdata | output | 8 | Command register read value |
| stat_rdata | output | 8 | Status register read value |
| route_sel | output | 4 | Active-half select per table |

## Verification
The assertions assume that `part_mode` bit 0 alone decides whether swaps are allowed. They also assume that both resets are only released while the inputs are quiet, so that an armed request can change only through its own strobe or a reset.

The stimulus changes every input at the falling edge of the clock. It asserts and releases the resets between edges. It sweeps all four modes against all four tables, covering own and foreign strobes. It then runs a pseudo-random phase whose mode, writes and strobes stay inside that contract.

// File: rtl/rsw_pkg.sv
package rsw_pkg;
    localparam int N_TBL = 4;
    localparam int REG_W = 8;
    localparam int MODE_W = 2;

    typedef enum logic {
        ST_IDLE    = 1'b0,
        ST_PENDING = 1'b1
    } tbl_state_e;
endpackage

// File: rtl/rsw_table_fsm.sv
module rsw_table_fsm
    import rsw_pkg::*;
(
    input  logic clk,
    input  logic hard_rst_n,
    input  logic soft_rst_n,
    input  logic mode_ok,
    input  logic set_req,
    input  logic fsync,
    output logic req_pending,
    output logic sel
);
    tbl_state_e state_q, state_d;
    logic       fire;
    logic       cmd_rst_n;

    assign cmd_rst_n = hard_rst_n & soft_rst_n;

    // state register: cleared by either reset
    always_ff @(posedge clk or negedge cmd_rst_n) begin
        if (!cmd_rst_n) state_q <= ST_IDLE;
        else            state_q <= state_d;
    end

    // transitions T_ARM / T_FIRE / T_HOLD
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (mode_ok && set_req) state_d = ST_PENDING;
            ST_PENDING: if (mode_ok && fsync)   state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        req_pending = (state_q == ST_PENDING);
        fire        = (state_q == ST_PENDING) && mode_ok && fsync;
    end

    // active-half select: hard reset only
    always_ff @(posedge clk or negedge hard_rst_n) begin
        if (!hard_rst_n) sel <= 1'b0;
        else if (fire)   sel <= ~sel;
    end
endmodule

// File: rtl/route_swap_ctrl.sv
module route_swap_ctrl
    import rsw_pkg::*;
#(
    parameter int NT = N_TBL,
    parameter int RW = REG_W
) (
    input  logic              clk,
    input  logic              hard_rst_n,
    input  logic              soft_rst_n,
    input  logic [MODE_W-1:0] part_mode,
    input  logic              reg_we,
    input  logic              reg_addr,
    input  logic [RW-1:0]     reg_wdata,
    input  logic [NT-1:0]     fsync,
    output logic [RW-1:0]     cmd_rdata,
    output logic [RW-1:0]     stat_rdata,
    output logic [NT-1:0]     route_sel
);
    localparam int PAD_W = RW - NT;

    logic          mode_ok;
    logic          cmd_wr;
    logic [NT-1:0] pend;
    logic [NT-1:0] sel;

    // modes 01 and 11 partition the memory for dynamic changes
    assign mode_ok = part_mode[0];
    // status writes (reg_addr=1) are decoded to nothing
    assign cmd_wr  = reg_we && (reg_addr == 1'b0);

    for (genvar i = 0; i < NT; i++) begin : g_tbl
        rsw_table_fsm u_fsm (
            .clk         (clk),
            .hard_rst_n  (hard_rst_n),
            .soft_rst_n  (soft_rst_n),
            .mode_ok     (mode_ok),
            .set_req     (cmd_wr && reg_wdata[i]),
            .fsync       (fsync[i]),
            .req_pending (pend[i]),
            .sel         (sel[i])
        );
    end

    assign cmd_rdata  = {{PAD_W{1'b0}}, pend};
    assign stat_rdata = {{PAD_W{1'b0}}, sel};
    assign route_sel  = sel;
endmodule

// File: rtl/rsw_chk.sv
module rsw_chk #(
    parameter int NT = 4,
    parameter int RW = 8
) (
    input logic          clk,
    input logic          hard_rst_n,
    input logic          soft_rst_n,
    input logic [1:0]    part_mode,
    input logic [NT-1:0] fsync,
    input logic [RW-1:0] cmd_rdata,
    input logic [RW-1:0] stat_rdata
);
    for (genvar i = 0; i < NT; i++) begin : g_a
        // R4: swap toggles status and clears request together
        p_swap_r4: assert property (@(posedge clk) disable iff (!hard_rst_n || !soft_rst_n)
            cmd_rdata[i] && fsync[i] && part_mode[0]
            |=> !cmd_rdata[i] && (stat_rdata[i] != $past(stat_rdata[i])));
        // R5 / R10: an armed request only leaves through its own swap
        p_no_cancel_r5: assert property (@(posedge clk) disable iff (!hard_rst_n || !soft_rst_n)
            cmd_rdata[i] && !(fsync[i] && part_mode[0]) |=> cmd_rdata[i]);
        // R3: disallowed mode never arms a request
        p_no_arm_r3: assert property (@(posedge clk) disable iff (!hard_rst_n || !soft_rst_n)
            !part_mode[0] && !cmd_rdata[i] |=> !cmd_rdata[i]);
        // R6 / R8: status moves only on a swap, soft reset included
        p_stat_hold_r6: assert property (@(posedge clk) disable iff (!hard_rst_n)
            !(cmd_rdata[i] && fsync[i] && part_mode[0] && soft_rst_n)
            |=> $stable(stat_rdata[i]));
    end
endmodule

bind route_swap_ctrl rsw_chk #(.NT(NT), .RW(RW)) u_rsw_chk (
    .clk        (clk),
    .hard_rst_n (hard_rst_n),
    .soft_rst_n (soft_rst_n),
    .part_mode  (part_mode),
    .fsync      (fsync),
    .cmd_rdata  (cmd_rdata),
    .stat_rdata (stat_rdata)
);

// File: tb/test_route_swap_ctrl.sv
module test_route_swap_ctrl;
    logic       clk = 1'b0;
    logic       hard_rst_n = 1'b0;
    logic       soft_rst_n = 1'b1;
    logic [1:0] part_mode = 2'b00;
    logic       reg_we = 1'b0;
    logic       reg_addr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [3:0] fsync = 4'h0;
    logic [7:0] cmd_rdata, stat_rdata;
    logic [3:0] route_sel;

    int vectors = 0;
    int errors  = 0;
    logic [3:0] m_cmd = 4'h0;
    logic [3:0] m_stat = 4'h0;

    always #5 clk = ~clk;

    route_swap_ctrl i_route_swap_ctrl (
        .clk(clk), .hard_rst_n(hard_rst_n), .soft_rst_n(soft_rst_n),
        .part_mode(part_mode), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .fsync(fsync), .cmd_rdata(cmd_rdata),
        .stat_rdata(stat_rdata), .route_sel(route_sel)
    );

    task automatic compare(input string tag);
        vectors++;
        if (cmd_rdata !== {4'h0, m_cmd}) begin
            errors++;
            $display("FAIL %s cmd act=%h exp=%h", tag, cmd_rdata, {4'h0, m_cmd});
        end
        if (stat_rdata !== {4'h0, m_stat}) begin
            errors++;
            $display("FAIL %s stat act=%h exp=%h", tag, stat_rdata, {4'h0, m_stat});
        end
        if (route_sel !== m_stat) begin
            errors++;
            $display("FAIL R7 %s sel act=%h exp=%h", tag, route_sel, m_stat);
        end
    endtask

    // called at a falling edge; applies one clock and checks at the next falling edge
    task automatic tick(input logic we, input logic adr, input logic [7:0] wd,
                        input logic [3:0] fs, input string tag);
        logic [3:0] fire, arm;
        reg_we = we; reg_addr = adr; reg_wdata = wd; fsync = fs;
        fire = part_mode[0] ? (m_cmd & fs) : 4'h0;
        arm  = (part_mode[0] && we && !adr) ? (wd[3:0] & ~m_cmd) : 4'h0;
        @(posedge clk);
        m_stat = m_stat ^ fire;
        m_cmd  = (m_cmd & ~fire) | arm;
        @(negedge clk);
        reg_we = 1'b0; fsync = 4'h0; reg_wdata = 8'h00;
        compare(tag);
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        logic [15:0] lfsr;
        @(negedge clk); @(negedge clk);
        compare("R9 reset");
        hard_rst_n = 1'b1;
        @(negedge clk);

        // sweep: every mode x every table
        for (int md = 0; md < 4; md++) begin
            for (int t = 0; t < 4; t++) begin
                part_mode = md[1:0];
                tick(1'b1, 1'b0, 8'hF0 | (8'h01 << t), 4'h0, "R2 R3 arm (R1 reserved)");
                tick(1'b0, 1'b0, 8'h00, 4'hF & ~(4'h1 << t), "R4 foreign strobe");
                tick(1'b1, 1'b0, 8'h00, 4'h0, "R5 write zero");
                tick(1'b1, 1'b0, 8'h01 << t, 4'h0, "R5 rewrite one");
                tick(1'b1, 1'b1, 8'hFF, 4'h0, "R6 status write");
                tick(1'b0, 1'b0, 8'h00, 4'h1 << t, "R4 own strobe");
            end
        end

        // R10: pending survives a disallowed mode
        part_mode = 2'b11;
        tick(1'b1, 1'b0, 8'h0F, 4'h0, "R10 arm all");
        part_mode = 2'b10;
        tick(1'b0, 1'b0, 8'h00, 4'hF, "R10 strobe in blocked mode");
        part_mode = 2'b01;
        tick(1'b0, 1'b0, 8'h00, 4'h5, "R10 strobe after re-enable");

        // R8: soft reset clears requests, keeps status
        soft_rst_n = 1'b0;
        m_cmd = 4'h0;
        @(negedge clk);
        compare("R8 soft reset");
        soft_rst_n = 1'b1;
        @(negedge clk);
        tick(1'b0, 1'b0, 8'h00, 4'hF, "R8 no swap after soft reset");

        // pseudo-random phase
        lfsr = 16'hACE1;
        for (int n = 0; n < 400; n++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            part_mode = (lfsr[9:7] == 3'd0) ? {lfsr[3], 1'b0} : {lfsr[3], 1'b1};
            tick(lfsr[0], lfsr[1], {lfsr[15:12], lfsr[11:8]}, lfsr[7:4] & {4{lfsr[2]}},
                 "R4 random");
        end

        // R9: hard reset clears both
        hard_rst_n = 1'b0;
        m_cmd = 4'h0; m_stat = 4'h0;
        @(negedge clk);
        compare("R9 hard reset");
        hard_rst_n = 1'b1;
        @(negedge clk);
        compare("R9 after release");

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule